// File: doc/BRIEF.md
# Programmable Two-Phase Non-Overlapping Clock Generator

This block derives two non-overlapping clock phases from a fast reference clock. A single output cycle is built from four intervals that always come in the same order. First phase one is high. Then comes a gap in which both phases are low. Then phase two is high. The cycle ends with a second gap in which both phases are low. Each interval is programmed on its own input as a count of reference-clock ticks. Widening the two gaps buys more tolerance to skew between the phases downstream.

Besides the two phases, the block drives the inverse of each phase. It also drives one gated (qualified) pulse per phase, which follows its phase only on cycles whose enable was set. Each enable is sampled only while the opposite phase is high. It is then held, so it cannot move while its own gated pulse is up. A one-tick strobe marks the start of every cycle. Every output leaves a flop clocked by the reference clock, so no output can glitch.

Top module: `tpc_gen`

## Requirements
- R1: After reset is released, the first rising edge of the reference clock starts a cycle in the phase-one-high interval. Intervals then repeat in the fixed order: phase one high, gap, phase two high, gap.
- R2: Each interval lasts exactly its programmed tick count, an unsigned binary value. A programmed 0 lasts 1 tick. The cycle period is the sum of the four effective lengths.
- R3: `ph1` and `ph2` are never high in the same tick. At least one tick with both low separates the fall of either phase from the rise of the other.
- R4: `ph1_n` is the inverse of `ph1` and `ph2_n` is the inverse of `ph2` in every tick, including during reset.
- R5: `qph1` is high exactly in the ticks where `ph1` is high and the held phase-one enable is 1. `qph2` follows the same rule with `ph2` and the held phase-two enable.
- R6: The held phase-one enable takes the value `en_q1` had in the last tick of the preceding phase-two-high interval. `en_q1` is ignored in all other ticks. It is 0 after reset, so the first phase-one pulse after reset is never qualified.
- R7: The held phase-two enable takes the value `en_q2` had in the last tick of the phase-one-high interval of the same cycle. `en_q2` is ignored in all other ticks.
- R8: The length inputs are captured only at the edge that starts a cycle. A change made in mid-cycle leaves the running cycle unchanged and applies from the next cycle on.
- R9: While `rst_n` is low, `ph1`, `ph2`, `qph1`, `qph2` and `cyc_start` are 0, and `ph1_n` and `ph2_n` are 1.
- R10: `cyc_start` is high for exactly the first tick of each phase-one-high interval and low in every other tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| len_p1 | input | LEN_W | Ticks of phase one high |
| len_g12 | input | LEN_W | Ticks from phase one falling to phase two rising |
| len_p2 | input | LEN_W | Ticks of phase two high |
| len_g21 | input | LEN_W | Ticks from phase two falling to phase one rising |
| en_q1 | input | 1 | Enable for the gated phase-one output |
| en_q2 | input | 1 | Enable for the gated phase-two output |
| ph1 | output | 1 | Phase one |
| ph2 | output | 1 | Phase two |
| ph1_n | output | 1 | Inverse of phase one |
| ph2_n | output | 1 | Inverse of phase two |
| qph1 | output | 1 | Gated phase one |
| qph2 | output | 1 | Gated phase two |
| cyc_start | output | 1 | One-tick strobe at each phase-one rise |

## Verification
The hardest case to reach from the ports is proving that an enable is really held. A wrong toggle on an enable outside its sampling window only shows if it lands in exactly the ticks that would corrupt the next gated pulse. The stimulus handles this by driving each enable to one per-cycle pattern bit inside the opposite phase's high interval and to its inverse in every other tick. The expected gated pulses then follow the pattern only if the out-of-window values are ignored. A second hard case is a mid-cycle change of the lengths. The stimulus rewrites all four lengths two ticks into a cycle and checks the old waveform through to the end of that cycle and the new one after it.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int NUM_IV = 4;

  typedef enum logic [1:0] {
    IV_P1  = 2'd0,
    IV_G12 = 2'd1,
    IV_P2  = 2'd2,
    IV_G21 = 2'd3
  } iv_e;
endpackage

// File: rtl/tpc_lenbank.sv
module tpc_lenbank
  import tpc_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [NUM_IV-1:0][LEN_W-1:0] len_raw,
  output logic [NUM_IV-1:0][LEN_W-1:0] len_now,
  output logic [NUM_IV-1:0][LEN_W-1:0] len_sh
);
  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [NUM_IV-1:0][LEN_W-1:0] len_sh_nxt;

  for (genvar i = 0; i < NUM_IV; i++) begin : g_iv
    // a zero length is raised to one tick so no gap can collapse
    assign len_now[i]    = (len_raw[i] == '0) ? ONE : len_raw[i];
    assign len_sh_nxt[i] = load ? len_now[i] : len_sh[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_sh <= {NUM_IV{ONE}};
    else        len_sh <= len_sh_nxt;
  end

  // R8: shadow lengths move only on a cycle-start load
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(len_sh));
endmodule

// File: rtl/tpc_seq.sv
module tpc_seq
  import tpc_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_IV-1:0][LEN_W-1:0] len_now,
  input  logic [NUM_IV-1:0][LEN_W-1:0] len_sh,
  output logic                         load,
  output logic [1:0]                   ph_nxt,
  output logic [1:0]                   ph_q,
  output logic [1:0]                   ph_qn,
  output logic                         cyc_start
);
  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  iv_e              st, st_nxt;
  logic [LEN_W-1:0] cnt, cnt_nxt;
  logic             adv;

  always_comb begin
    adv     = (cnt == '0);
    st_nxt  = st;
    cnt_nxt = cnt - ONE;
    if (adv) begin
      st_nxt = iv_e'(st + 2'd1);
      if (st_nxt == IV_P1) cnt_nxt = len_now[IV_P1] - ONE;
      else                 cnt_nxt = len_sh[st_nxt] - ONE;
    end
    load      = adv && (st == IV_G21);
    ph_nxt[0] = (st_nxt == IV_P1);
    ph_nxt[1] = (st_nxt == IV_P2);
  end

  // reset parks in the closing gap with an expired count: first edge opens phase one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= IV_G21;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= 2'b00;
      ph_qn     <= 2'b11;
      cyc_start <= 1'b0;
    end else begin
      ph_q      <= ph_nxt;
      ph_qn     <= ~ph_nxt;
      cyc_start <= load;
    end
  end

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_q[0] && ph_q[1]));
  p_gap_after_p1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_q[0]) |-> !ph_q[1]);
  p_gap_after_p2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_q[1]) |-> !ph_q[0]);
  p_complement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_qn[0] == !ph_q[0]) && (ph_qn[1] == !ph_q[1]));
  p_start_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (ph_q[0] && !$past(ph_q[0])));
  p_rise_has_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_q[0]) |-> cyc_start);
endmodule

// File: rtl/tpc_qual.sv
module tpc_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_win,
  input  logic en,
  input  logic own_nxt,
  input  logic own_q,
  output logic q
);
  logic hold, hold_nxt;

  // enable captured only while the opposite phase is high
  assign hold_nxt = smp_win ? en : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0;
      q    <= 1'b0;
    end else begin
      hold <= hold_nxt;
      q    <= own_nxt & hold;
    end
  end

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q && $past(own_q)) |-> $stable(hold));
  p_qual_in_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q |-> own_q);
  p_qual_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q && $past(own_q)) |-> $stable(q));
endmodule

// File: rtl/tpc_gen.sv
module tpc_gen
  import tpc_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_p1,
  input  logic [LEN_W-1:0] len_g12,
  input  logic [LEN_W-1:0] len_p2,
  input  logic [LEN_W-1:0] len_g21,
  input  logic             en_q1,
  input  logic             en_q2,
  output logic             ph1,
  output logic             ph2,
  output logic             ph1_n,
  output logic             ph2_n,
  output logic             qph1,
  output logic             qph2,
  output logic             cyc_start
);
  logic [NUM_IV-1:0][LEN_W-1:0] len_raw, len_now, len_sh;
  logic                         load;
  logic [1:0]                   ph_nxt, ph_q, ph_qn, q, en;

  assign len_raw[IV_P1]  = len_p1;
  assign len_raw[IV_G12] = len_g12;
  assign len_raw[IV_P2]  = len_p2;
  assign len_raw[IV_G21] = len_g21;
  assign en              = {en_q2, en_q1};

  tpc_lenbank #(.LEN_W(LEN_W)) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .len_raw (len_raw),
    .len_now (len_now),
    .len_sh  (len_sh)
  );

  tpc_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_now   (len_now),
    .len_sh    (len_sh),
    .load      (load),
    .ph_nxt    (ph_nxt),
    .ph_q      (ph_q),
    .ph_qn     (ph_qn),
    .cyc_start (cyc_start)
  );

  // each gate samples its enable while the other phase is high
  for (genvar p = 0; p < 2; p++) begin : g_qual
    tpc_qual u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_win (ph_q[1-p]),
      .en      (en[p]),
      .own_nxt (ph_nxt[p]),
      .own_q   (ph_q[p]),
      .q       (q[p])
    );
  end

  assign ph1   = ph_q[0];
  assign ph2   = ph_q[1];
  assign ph1_n = ph_qn[0];
  assign ph2_n = ph_qn[1];
  assign qph1  = q[0];
  assign qph2  = q[1];
endmodule

// File: tb/tpc_gen_test.sv
module tpc_gen_test;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] len_p1 = '0, len_g12 = '0, len_p2 = '0, len_g21 = '0;
  logic          en_q1 = 1'b0, en_q2 = 1'b0;
  logic          ph1, ph2, ph1_n, ph2_n, qph1, qph2, cyc_start;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tpc_gen #(.LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n),
    .len_p1(len_p1), .len_g12(len_g12), .len_p2(len_p2), .len_g21(len_g21),
    .en_q1(en_q1), .en_q2(en_q2),
    .ph1(ph1), .ph2(ph2), .ph1_n(ph1_n), .ph2_n(ph2_n),
    .qph1(qph1), .qph2(qph2), .cyc_start(cyc_start)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic set_len(input int a, input int b, input int c, input int d);
    len_p1 = LW'(a); len_g12 = LW'(b); len_p2 = LW'(c); len_g21 = LW'(d);
  endtask

  // reset, checking R9 values while held; release at a falling edge
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "ph1 in reset", ph1, 0);
    chk("R9", "ph2 in reset", ph2, 0);
    chk("R9", "ph1_n in reset", ph1_n, 1);
    chk("R9", "ph2_n in reset", ph2_n, 1);
    chk("R9", "qph1 in reset", qph1, 0);
    chk("R9", "qph2 in reset", qph2, 0);
    chk("R9", "cyc_start in reset", cyc_start, 0);
    rst_n = 1'b1;
  endtask

  // phase waveform for tick position pos in a cycle of lengths a,b,c
  task automatic chk_tick(input string tag, input int pos, input int a, input int b, input int c);
    int e1, e2;
    e1 = (pos < a) ? 1 : 0;
    e2 = (pos >= a + b && pos < a + b + c) ? 1 : 0;
    chk({tag, " R1 R2"}, "ph1", ph1, e1);
    chk({tag, " R2 R3"}, "ph2", ph2, e2);
    chk({tag, " R4"}, "ph1_n", ph1_n, 1 - e1);
    chk({tag, " R4"}, "ph2_n", ph2_n, 1 - e2);
    chk({tag, " R10"}, "cyc_start", cyc_start, (pos == 0) ? 1 : 0);
  endtask

  task automatic t_pattern(input string tag, input int a, input int b, input int c, input int d,
                           input int ncyc);
    int ea, eb, ec, per;
    set_len(a, b, c, d);
    do_reset();
    ea = eff(a); eb = eff(b); ec = eff(c);
    per = ea + eb + ec + eff(d);
    for (int k = 0; k < ncyc * per; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk_tick(tag, k % per, ea, eb, ec);
    end
  endtask

  // R8: lengths rewritten two ticks into the first cycle
  task automatic t_reload();
    int po, pn, pos;
    set_len(3, 2, 4, 1);
    do_reset();
    po = 10; pn = 8;
    for (int k = 0; k < po + 2 * pn; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < po) chk_tick("R8 old", k, 3, 2, 4);
      else begin
        pos = (k - po) % pn;
        chk_tick("R8 new", pos, 1, 3, 2);
      end
      if (k == 2) set_len(1, 3, 2, 2);
    end
  endtask

  // R5 R6 R7: enables set per cycle inside window, inverted outside
  task automatic t_qual();
    logic [7:0] pat1, pat2;
    int a, b, c, per, cy, pos, e1, e2;
    a = 2; b = 1; c = 3; per = 7;
    pat1 = 8'b0110_1101;
    pat2 = 8'b1001_1010;
    set_len(2, 1, 3, 1);
    en_q1 = 1'b1; en_q2 = 1'b1;
    do_reset();
    for (int k = 0; k < 6 * per; k++) begin
      @(posedge clk);
      @(negedge clk);
      cy  = k / per;
      pos = k % per;
      e1 = (pos < a) ? 1 : 0;
      e2 = (pos >= a + b && pos < a + b + c) ? 1 : 0;
      chk("R5 R6", "qph1", qph1, (e1 == 1 && cy > 0 && pat1[cy]) ? 1 : 0);
      chk("R5 R7", "qph2", qph2, (e2 == 1 && pat2[cy]) ? 1 : 0);
      en_q1 = (e2 == 1) ? pat1[cy+1] : ~pat1[cy+1];
      en_q2 = (e1 == 1) ? pat2[cy] : ~pat2[cy];
    end
    en_q1 = 1'b0; en_q2 = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_pattern("base", 3, 2, 4, 1, 3);
    t_pattern("ones", 1, 1, 1, 1, 4);
    t_pattern("zeros", 0, 0, 0, 0, 4);
    t_pattern("mixed", 5, 0, 2, 3, 3);
    t_pattern("wide", 7, 4, 6, 5, 2);
    t_reload();
    t_qual();
    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule